// File: doc/BRIEF.md
# Bidirectional Column Strobe Sequencer

This block produces the per-column sampling strobes for a column driver with `NUM_OUT` outputs. Column 1 sits at strobe bit 0. A start pulse arrives on one of two bidirectional pads. Its falling edge arms a walk, and the walk begins on the next rising edge of the horizontal shift clock.

The walk moves one position on every shift-clock level change, that is, on every half clock. Each strobe stays high for two half clocks, so neighbouring strobes overlap by one half clock. In group mode, three adjacent columns are strobed together, which divides the number of steps by three.

A direction input chooses two things: which end the walk starts from, and which pad takes the start pulse. The other pad carries a cascade pulse that starts the next driver in a chain. That pulse ends early enough for the next driver to begin its walk on the half-step right after this one's last step.

The shift clock reaches the block as a level sampled by a system clock at least twice its rate. Each pad is modelled as three separate signals: in, out and output-enable.

Top module: `col_strobe_seq`

## Requirements
- R1: Reset behaviour. While reset is high and in the first cycle after it, every strobe is low and both pad outputs are low.
- R2: Pad roles. With `dir_fwd`=1, pad A is the start input (`pad_a_oe`=0, `pad_a_out`=0) and pad B drives the cascade (`pad_b_oe`=1). With `dir_fwd`=0 the roles swap.
- R3: Arming. A start pulse is armed when the start pad is seen high in one system cycle and low in the next. The first step is the first rising shift-clock level change seen in that same cycle or later. Step 0 strobes are visible after that system clock edge.
- R4: Overlap. Walk step k asserts its strobes at half-step k and holds them through half-step k+1. Between step 1 and the last step, exactly two steps' strobes are high at once.
- R5: Single-column order (`grp_mode`=0). There are `NUM_OUT` steps. Step s strobes bit s when `dir_fwd`=1, and bit `NUM_OUT`-1-s when `dir_fwd`=0.
- R6: Group order (`grp_mode`=1). There are `NUM_OUT`/3 steps. Group g covers bits 3g, 3g+1 and 3g+2, and all three are strobed together. Step s strobes group s when walking forward, and group `NUM_OUT`/3-1-s when walking in reverse.
- R7: End of walk. After the last step has been held for its second half-step, the next level change drops all strobes. They then stay low until the next start pulse.
- R8: Cascade pulse. With S steps, the cascade pad output is high exactly while the walk is at half-step S-3 or S-2. At any other time it is low.
- R9: Restart. A start fall during a walk abandons it. If no rising step comes in the same cycle, all strobes go low. The next rising step restarts the walk at step 0.
- R10: Walk settings are latched. Mode and direction are captured at the start fall. Changing `grp_mode` during a walk does not change the strobe pattern.
- R11: Hold. While the shift-clock level, the pads and `dir_fwd` stay unchanged, the strobes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least twice the shift-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| shclk_lvl | input | 1 | Sampled level of the horizontal shift clock |
| dir_fwd | input | 1 | 1: walk from bit 0 upward, start on pad A; 0: reverse, start on pad B |
| grp_mode | input | 1 | 0: one column per step; 1: three columns per step |
| pad_a_in | input | 1 | Pad A input value |
| pad_a_out | output | 1 | Pad A output value (cascade when dir_fwd=0) |
| pad_a_oe | output | 1 | Pad A output enable |
| pad_b_in | input | 1 | Pad B input value |
| pad_b_out | output | 1 | Pad B output value (cascade when dir_fwd=1) |
| pad_b_oe | output | 1 | Pad B output enable |
| strobe | output | NUM_OUT | Sampling strobes, bit i for column i+1 |

## Verification
The bench drives the shift clock at full rate, so a start fall can land in the same cycle as a rising step or a falling one. A design that armed on the pulse's rising edge, or that let a falling step begin the walk, would put step 0 one half-step off.

Restarts are tested both while the clock runs and while it is stopped. A design that kept the old position would keep strobing mid-row columns instead of returning to the first column.

The bench flips `grp_mode` in the middle of a reverse group walk. A design that follows the live input would jump from group strobes to single ones.

The last steps and the cascade window are compared cycle by cycle in both directions and both modes. An off-by-one in the end count shows up as a lingering strobe. An off-by-one in the cascade window shows up as a pulse that falls on the wrong half-step.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ARMED = 2'd1,
        WALK_RUN   = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic group;
        logic fwd;
    } walk_cfg_t;

    typedef struct packed {
        logic rise;
        logic step;
        logic start_fall;
    } seq_evt_t;

    localparam int unsigned GROUP_W = 3;

    function automatic int unsigned steps_for(input logic group,
                                              input int unsigned n_out,
                                              input int unsigned grp);
        return group ? (n_out / grp) : n_out;
    endfunction

endpackage

// File: rtl/cs_event_detect.sv
module cs_event_detect
    import cs_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sh_lvl,
    input  logic     start_lvl,
    output seq_evt_t evt
);

    logic sh_q;
    logic st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= sh_lvl;
            st_q <= start_lvl;
        end else begin
            sh_q <= sh_lvl;
            st_q <= start_lvl;
        end
    end

    always_comb begin
        evt.rise       = sh_lvl & ~sh_q;
        evt.step       = sh_lvl ^ sh_q;
        evt.start_fall = st_q & ~start_lvl;
    end

endmodule

// File: rtl/cs_walk_ctrl.sv
module cs_walk_ctrl
    import cs_seq_pkg::*;
#(
    parameter int unsigned NUM_OUT = 240,
    parameter int unsigned GRP     = GROUP_W,
    parameter int unsigned CW      = $clog2(NUM_OUT + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_evt_t      evt,
    input  logic          group_req,
    input  logic          fwd_req,
    output walk_cfg_t     cfg,
    output logic          running,
    output logic [CW-1:0] pos,
    output logic [CW-1:0] steps,
    output logic          casc
);

    walk_state_e   state_q;
    logic [CW-1:0] pos_q;
    walk_cfg_t     cfg_q;

    always_comb begin
        steps = CW'(steps_for(cfg_q.group, NUM_OUT, GRP));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            pos_q   <= '0;
            cfg_q   <= '0;
        end else if (evt.start_fall) begin
            cfg_q.group <= group_req;
            cfg_q.fwd   <= fwd_req;
            pos_q       <= '0;
            state_q     <= evt.rise ? WALK_RUN : WALK_ARMED;
        end else begin
            case (state_q)
                WALK_ARMED: begin
                    if (evt.rise) begin
                        state_q <= WALK_RUN;
                        pos_q   <= '0;
                    end
                end
                WALK_RUN: begin
                    if (evt.step) begin
                        if (pos_q == steps) begin
                            state_q <= WALK_IDLE;
                            pos_q   <= '0;
                        end else begin
                            pos_q <= pos_q + CW'(1);
                        end
                    end
                end
                default: begin
                    pos_q <= pos_q;
                end
            endcase
        end
    end

    always_comb begin
        running = (state_q == WALK_RUN);
        pos     = pos_q;
        cfg     = cfg_q;
        casc    = running && ((pos_q == steps - CW'(3)) || (pos_q == steps - CW'(2)));
    end

endmodule

// File: rtl/cs_strobe_decode.sv
module cs_strobe_decode
    import cs_seq_pkg::*;
#(
    parameter int unsigned NUM_OUT = 240,
    parameter int unsigned GRP     = GROUP_W,
    parameter int unsigned CW      = $clog2(NUM_OUT + 2)
) (
    input  logic               running,
    input  walk_cfg_t          cfg,
    input  logic [CW-1:0]      pos,
    input  logic [CW-1:0]      steps,
    output logic [NUM_OUT-1:0] strobe
);

    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_col
        localparam logic [CW-1:0] POS_SINGLE = CW'(gi);
        localparam logic [CW-1:0] POS_GROUP  = CW'(gi / GRP);
        logic [CW-1:0] fwd_pos;
        logic [CW-1:0] ord_pos;
        always_comb begin
            fwd_pos    = cfg.group ? POS_GROUP : POS_SINGLE;
            ord_pos    = cfg.fwd ? fwd_pos : (steps - CW'(1) - fwd_pos);
            strobe[gi] = running && ((pos == ord_pos) || (pos == ord_pos + CW'(1)));
        end
    end

endmodule

// File: rtl/cs_pin_router.sv
module cs_pin_router (
    input  logic dir_fwd,
    input  logic a_in,
    input  logic b_in,
    input  logic casc,
    output logic start_lvl,
    output logic a_out,
    output logic a_oe,
    output logic b_out,
    output logic b_oe
);

    always_comb begin
        start_lvl = dir_fwd ? a_in : b_in;
        a_oe      = ~dir_fwd;
        b_oe      = dir_fwd;
        a_out     = ~dir_fwd & casc;
        b_out     = dir_fwd & casc;
    end

endmodule

// File: rtl/col_strobe_seq.sv
module col_strobe_seq
    import cs_seq_pkg::*;
#(
    parameter int unsigned NUM_OUT = 240,
    parameter int unsigned GRP     = GROUP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shclk_lvl,
    input  logic               dir_fwd,
    input  logic               grp_mode,
    input  logic               pad_a_in,
    output logic               pad_a_out,
    output logic               pad_a_oe,
    input  logic               pad_b_in,
    output logic               pad_b_out,
    output logic               pad_b_oe,
    output logic [NUM_OUT-1:0] strobe
);

    localparam int unsigned CW = $clog2(NUM_OUT + 2);

    seq_evt_t      evt;
    walk_cfg_t     cfg;
    logic          start_lvl;
    logic          running;
    logic          casc;
    logic [CW-1:0] pos;
    logic [CW-1:0] steps;

    cs_pin_router u_pins (
        .dir_fwd  (dir_fwd),
        .a_in     (pad_a_in),
        .b_in     (pad_b_in),
        .casc     (casc),
        .start_lvl(start_lvl),
        .a_out    (pad_a_out),
        .a_oe     (pad_a_oe),
        .b_out    (pad_b_out),
        .b_oe     (pad_b_oe)
    );

    cs_event_detect u_evt (
        .clk      (clk),
        .rst      (rst),
        .sh_lvl   (shclk_lvl),
        .start_lvl(start_lvl),
        .evt      (evt)
    );

    cs_walk_ctrl #(.NUM_OUT(NUM_OUT), .GRP(GRP), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .group_req(grp_mode),
        .fwd_req  (dir_fwd),
        .cfg      (cfg),
        .running  (running),
        .pos      (pos),
        .steps    (steps),
        .casc     (casc)
    );

    cs_strobe_decode #(.NUM_OUT(NUM_OUT), .GRP(GRP), .CW(CW)) u_dec (
        .running(running),
        .cfg    (cfg),
        .pos    (pos),
        .steps  (steps),
        .strobe (strobe)
    );

endmodule

// File: rtl/cs_seq_checker.sv
module cs_seq_checker #(
    parameter int unsigned NUM_OUT = 240,
    parameter int unsigned GRP     = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               shclk_lvl,
    input logic               dir_fwd,
    input logic               pad_a_in,
    input logic               pad_b_in,
    input logic               pad_a_out,
    input logic               pad_a_oe,
    input logic               pad_b_out,
    input logic               pad_b_oe,
    input logic [NUM_OUT-1:0] strobe
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (strobe == '0 && !pad_a_out && !pad_b_out));

    assert_fwd_roles_R2: assert property (@(posedge clk) disable iff (rst)
        dir_fwd |-> (pad_b_oe && !pad_a_oe && !pad_a_out));

    assert_rev_roles_R2: assert property (@(posedge clk) disable iff (rst)
        !dir_fwd |-> (pad_a_oe && !pad_b_oe && !pad_b_out));

    assert_overlap_bound_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(strobe) <= 2 * GRP);

    assert_casc_in_walk_R8: assert property (@(posedge clk) disable iff (rst)
        (pad_a_out || pad_b_out) |-> (strobe != '0));

    assert_hold_when_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ($stable(shclk_lvl) && $stable(pad_a_in) && $stable(pad_b_in) && $stable(dir_fwd))
        |=> $stable(strobe));

endmodule

bind col_strobe_seq cs_seq_checker #(.NUM_OUT(NUM_OUT), .GRP(GRP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .shclk_lvl(shclk_lvl),
    .dir_fwd  (dir_fwd),
    .pad_a_in (pad_a_in),
    .pad_b_in (pad_b_in),
    .pad_a_out(pad_a_out),
    .pad_a_oe (pad_a_oe),
    .pad_b_out(pad_b_out),
    .pad_b_oe (pad_b_oe),
    .strobe   (strobe)
);

// File: tb/tb_col_strobe_seq.sv
module tb_col_strobe_seq;

    localparam int N = 240;
    localparam int G = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shclk = 1'b0;
    logic dir_fwd = 1'b1;
    logic grp_mode = 1'b0;
    logic pad_a_in = 1'b0;
    logic pad_b_in = 1'b0;
    logic pad_a_out, pad_a_oe, pad_b_out, pad_b_oe;
    logic [N-1:0] strobe;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R5";
    bit    cmp_en = 1'b0;
    bit    sh_en = 1'b0;
    int    sh_div = 1;
    int    div_cnt = 0;

    int m_state = 0;
    int m_h = 0;
    bit m_grp = 1'b0;
    bit m_fwd = 1'b0;
    bit m_prev_sh = 1'b0;
    bit m_prev_st = 1'b0;

    col_strobe_seq dut (
        .clk(clk), .rst(rst), .shclk_lvl(shclk), .dir_fwd(dir_fwd), .grp_mode(grp_mode),
        .pad_a_in(pad_a_in), .pad_a_out(pad_a_out), .pad_a_oe(pad_a_oe),
        .pad_b_in(pad_b_in), .pad_b_out(pad_b_out), .pad_b_oe(pad_b_oe),
        .strobe(strobe)
    );

    always #4 clk = ~clk;

    function automatic int m_steps();
        return m_grp ? N / G : N;
    endfunction

    function automatic logic [N-1:0] exp_strobe();
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) begin
            int fp = m_grp ? i / G : i;
            int op = m_fwd ? fp : m_steps() - 1 - fp;
            v[i] = (m_state == 2) && (m_h == op || m_h == op + 1);
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // reference model, state advanced on each system clock edge
    always @(posedge clk) begin
        bit cur_st, fall, rise, chg;
        cur_st = dir_fwd ? pad_a_in : pad_b_in;
        if (rst) begin
            m_state = 0;
            m_h = 0;
            m_grp = 1'b0;
            m_fwd = 1'b0;
        end else begin
            fall = m_prev_st && !cur_st;
            rise = shclk && !m_prev_sh;
            chg  = (shclk != m_prev_sh);
            if (fall) begin
                m_grp = grp_mode;
                m_fwd = dir_fwd;
                m_h = 0;
                m_state = rise ? 2 : 1;
            end else if (m_state == 1 && rise) begin
                m_state = 2;
                m_h = 0;
            end else if (m_state == 2 && chg) begin
                if (m_h == m_steps()) begin
                    m_state = 0;
                    m_h = 0;
                end else begin
                    m_h = m_h + 1;
                end
            end
        end
        m_prev_sh = shclk;
        m_prev_st = cur_st;
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            logic [N-1:0] es;
            bit ec;
            int s;
            s  = m_steps();
            es = exp_strobe();
            chk(strobe === es, cur_req, strobe, es);
            ec = (m_state == 2) && (m_h == s - 3 || m_h == s - 2);
            chk({pad_a_oe, pad_b_oe} === {!dir_fwd, dir_fwd}, "R2",
                N'({pad_a_oe, pad_b_oe}), N'({!dir_fwd, dir_fwd}));
            chk({pad_a_out, pad_b_out} === {!dir_fwd && ec, dir_fwd && ec}, "R8",
                N'({pad_a_out, pad_b_out}), N'({!dir_fwd && ec, dir_fwd && ec}));
            if (m_state == 2 && m_h >= 1 && m_h < s)
                chk($countones(strobe) == 2 * (m_grp ? G : 1), "R4",
                    N'($countones(strobe)), N'(2 * (m_grp ? G : 1)));
        end
    end

    // shift clock generator
    always @(negedge clk) begin
        #1;
        if (sh_en) begin
            div_cnt++;
            if (div_cnt >= sh_div) begin
                shclk = ~shclk;
                div_cnt = 0;
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input bit d, input bit g);
        @(negedge clk);
        #1;
        dir_fwd = d;
        grp_mode = g;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        #1;
        if (dir_fwd) pad_a_in = 1'b1; else pad_b_in = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        pad_a_in = 1'b0;
        pad_b_in = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        cycles(4);
        chk(strobe === '0, "R1", strobe, '0);
        chk({pad_a_out, pad_b_out} === 2'b00, "R1", N'({pad_a_out, pad_b_out}), '0);
        #1;
        rst = 1'b0;
        cycles(1);
        chk(strobe === '0, "R1", strobe, '0);
        cmp_en = 1'b1;
        sh_en = 1'b1;
        cycles(6);

        // R3 and R5: forward single walk
        cur_req = "R3";
        set_cfg(1'b1, 1'b0);
        pulse_start();
        begin
            int k = 0;
            while (strobe === '0 && k < 10) begin
                cycles(1);
                k++;
            end
            chk(strobe === N'(1), "R3", strobe, N'(1));
            chk(shclk === 1'b1, "R3", N'(shclk), N'(1));
        end
        cur_req = "R5";
        cycles(250);
        cur_req = "R7";
        cycles(12);

        // R5: reverse single walk
        cur_req = "R5";
        set_cfg(1'b0, 1'b0);
        cycles(3);
        pulse_start();
        cycles(250);
        cur_req = "R7";
        cycles(8);

        // R6: forward and reverse groups
        cur_req = "R6";
        set_cfg(1'b1, 1'b1);
        cycles(3);
        pulse_start();
        cycles(95);
        set_cfg(1'b0, 1'b1);
        cycles(3);
        pulse_start();
        cycles(95);

        // R10: mode flip during a reverse group walk
        cur_req = "R10";
        pulse_start();
        cycles(30);
        set_cfg(1'b0, 1'b0);
        cycles(70);

        // R9: restart while running, then with the clock stopped
        cur_req = "R9";
        set_cfg(1'b1, 1'b0);
        cycles(2);
        pulse_start();
        cycles(60);
        pulse_start();
        cycles(40);
        sh_en = 1'b0;
        pulse_start();
        cycles(5);
        chk(strobe === '0, "R9", strobe, '0);
        sh_en = 1'b1;
        cycles(260);

        // R11: slow shift clock, strobes hold between level changes
        cur_req = "R11";
        sh_div = 3;
        set_cfg(1'b1, 1'b1);
        cycles(2);
        pulse_start();
        cycles(270);
        cur_req = "R7";
        cycles(10);

        cmp_en = 1'b0;
        summary();
        $finish;
    end

endmodule